// File: doc/BRIEF.md
# ADC Result and Status Register Block

This block sits between a conversion engine of an eight-channel analog-to-digital converter and the register bus. Each time the engine finishes a conversion it gives a one-cycle completion pulse together with the channel number and the 10-bit result. The block copies that result into the result register of that channel and into one shared "latest result" register, and it keeps a completion flag and a lost-result flag for each of them.

Software reads results over a plain read/write bus. Reading a result register clears its flags. Writing the control word clears the completion flag of the shared register. A status word gathers all per-channel flags into one read, and reading it has no side effects. An interrupt line goes high when any channel has a finished result and that channel is enabled in an interrupt-enable mask. The line is registered, so it follows the flags one cycle later.

Top module: `adc_result_regs`

## Requirements
- R1: After reset, every result word, the status word, the control word and the interrupt-enable mask read as zero, and `irq` is low.
- R2: A result word has the completion flag at bit 31, the lost-result flag at bit 30, the channel number at bits 26:24 and the 10-bit value at bits 15:6. Bits 29:27, 23:16 and 5:0 are always zero.
- R3: A completion pulse stores the value and the channel in that channel's result register (address 4 + channel) and in the shared result register (address 1), and it sets the completion flag of both.
- R4: A bus read of a result register clears its completion and lost-result flags. When a completion pulse for the same register arrives in the same cycle, the pulse wins: the completion flag stays set, the new value is kept, and the lost-result flag ends up clear.
- R5: When burst mode is on (control word bit 0 = 1), a completion pulse that lands on a register whose completion flag is still set also sets that register's lost-result flag. When burst mode is off, no lost-result flag is set.
- R6: A write to the control word (address 0) clears the completion flag of the shared result register only and stores burst mode from write-data bit 0. Per-channel flags are not affected.
- R7: The status word (address 3) holds the per-channel completion flags at bits 7:0, the per-channel lost-result flags at bits 15:8, and the interrupt condition at bit 16. Bits 31:17 are zero.
- R8: Reading the status word changes no flag.
- R9: `irq` equals the OR of (completion flag AND enable bit) over all channels, delayed by one clock. Channels that are not enabled do not raise it.
- R10: The interrupt-enable mask at address 2 is written from write-data bits 7:0 and reads back in bits 7:0.
- R11: The extreme codes 0x000 (input at the low reference) and 0x3FF (input at or above the high reference) are stored and returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_valid | input | 1 | One-cycle conversion completion pulse |
| conv_ch | input | 3 | Channel of the completed conversion |
| conv_data | input | 10 | Conversion result |
| bus_addr | input | 4 | Word address of the register |
| bus_rd | input | 1 | Read strobe. Clear side effects happen at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Registered interrupt request |

## Verification
A table of eight captures across all channels checks how values and channel numbers are placed. The table includes both extreme codes, so a shifted or truncated value field shows up. Back-to-back captures on one channel, run once in burst mode and once outside it, tell apart the two lost-result behaviours. A capture and a read in the same cycle show whether the capture takes priority over the clear. Separate sequences for the control write, the status read and the interrupt mask show which clear paths reach which flags, and they check that `irq` follows the flags exactly one cycle later and ignores channels that are not enabled.

// File: rtl/adc_regs_pkg.sv
package adc_regs_pkg;
   // word addresses of the register map
   localparam int A_CTRL   = 0;
   localparam int A_GLOBAL = 1;
   localparam int A_INTEN  = 2;
   localparam int A_STATUS = 3;
   localparam int A_CHAN0  = 4;

   // build a result word: flags at the top, channel at 26:24, value at 15:6
   function automatic logic [31:0] pack_result(input logic       done,
                                                input logic       ovr,
                                                input logic [2:0] chan,
                                                input logic [9:0] val);
      return {done, ovr, 3'b000, chan, 8'h00, val, 6'b000000};
   endfunction
endpackage

// File: rtl/adc_flag_slot.sv
module adc_flag_slot #(
   parameter int RES_W = 10,
   parameter int CH_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap,
   input  logic [CH_W-1:0]  cap_ch,
   input  logic [RES_W-1:0] cap_val,
   input  logic             burst,
   input  logic             clr,
   output logic             done,
   output logic             ovr,
   output logic [RES_W-1:0] val,
   output logic [CH_W-1:0]  ch
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done <= 1'b0;
         ovr  <= 1'b0;
         val  <= '0;
         ch   <= '0;
      end else if (cap) begin
         // a capture wins over a clear in the same cycle
         val  <= cap_val;
         ch   <= cap_ch;
         done <= 1'b1;
         if (burst && done && !clr) ovr <= 1'b1;
         else if (clr)              ovr <= 1'b0;
      end else if (clr) begin
         done <= 1'b0;
         ovr  <= 1'b0;
      end
   end
endmodule

// File: rtl/adc_irq_gen.sv
module adc_irq_gen #(
   parameter int NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] done,
   input  logic [NUM_CH-1:0] en,
   output logic              pending,
   output logic              irq
);
   assign pending = |(done & en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= pending;
   end
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs
   import adc_regs_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int RES_W  = 10,
   parameter int ADDR_W = 4,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int SHIFT = 10 - RES_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_valid,
   input  logic [CH_W-1:0]   conv_ch,
   input  logic [RES_W-1:0]  conv_data,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [NUM_CH-1:0] bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq
);
   initial begin
      assert (NUM_CH >= 2 && NUM_CH <= 8) else $error("NUM_CH must be 2..8");
      assert (RES_W >= 1 && RES_W <= 10) else $error("RES_W must be 1..10");
      assert (A_CHAN0 + NUM_CH <= (1 << ADDR_W)) else $error("ADDR_W too small");
   end

   logic              burst_en;
   logic [NUM_CH-1:0] int_en;
   logic [NUM_CH-1:0] ch_done, ch_ovr, ch_cap, ch_clr;
   logic [31:0]       chan_word [NUM_CH];
   logic              g_done, g_ovr, g_clr, irq_pending;
   logic [RES_W-1:0]  g_val;
   logic [CH_W-1:0]   g_ch;
   logic [ADDR_W-1:0] rd_idx;

   wire wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
   wire wr_inten = bus_wr && (bus_addr == ADDR_W'(A_INTEN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         burst_en <= 1'b0;
         int_en   <= '0;
      end else begin
         if (wr_ctrl)  burst_en <= bus_wdata[0];
         if (wr_inten) int_en   <= bus_wdata;
      end
   end

   // one slot per channel
   for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
      logic [RES_W-1:0] val_k;
      logic [CH_W-1:0]  id_k;
      assign ch_cap[k] = conv_valid && (conv_ch == CH_W'(k));
      assign ch_clr[k] = bus_rd && (bus_addr == ADDR_W'(A_CHAN0 + k));
      adc_flag_slot #(.RES_W(RES_W), .CH_W(CH_W)) u_slot (
         .clk(clk), .rst_n(rst_n), .cap(ch_cap[k]), .cap_ch(conv_ch),
         .cap_val(conv_data), .burst(burst_en), .clr(ch_clr[k]),
         .done(ch_done[k]), .ovr(ch_ovr[k]), .val(val_k), .ch(id_k));
      assign chan_word[k] = pack_result(ch_done[k], ch_ovr[k], 3'(id_k),
                                        10'(val_k) << SHIFT);
   end

   // shared latest-result slot
   assign g_clr = (bus_rd && (bus_addr == ADDR_W'(A_GLOBAL))) || wr_ctrl;
   adc_flag_slot #(.RES_W(RES_W), .CH_W(CH_W)) u_global (
      .clk(clk), .rst_n(rst_n), .cap(conv_valid), .cap_ch(conv_ch),
      .cap_val(conv_data), .burst(burst_en), .clr(g_clr),
      .done(g_done), .ovr(g_ovr), .val(g_val), .ch(g_ch));

   adc_irq_gen #(.NUM_CH(NUM_CH)) u_irq (
      .clk(clk), .rst_n(rst_n), .done(ch_done), .en(int_en),
      .pending(irq_pending), .irq(irq));

   always_comb begin
      bus_rdata = '0;
      rd_idx    = bus_addr - ADDR_W'(A_CHAN0);
      if (bus_addr == ADDR_W'(A_CTRL))
         bus_rdata = {31'b0, burst_en};
      else if (bus_addr == ADDR_W'(A_GLOBAL))
         bus_rdata = pack_result(g_done, g_ovr, 3'(g_ch), 10'(g_val) << SHIFT);
      else if (bus_addr == ADDR_W'(A_INTEN))
         bus_rdata = 32'(int_en);
      else if (bus_addr == ADDR_W'(A_STATUS))
         bus_rdata = {15'b0, irq_pending, 8'(ch_ovr), 8'(ch_done)};
      else if (bus_addr >= ADDR_W'(A_CHAN0) && rd_idx < ADDR_W'(NUM_CH))
         bus_rdata = chan_word[rd_idx[CH_W-1:0]];
   end
endmodule

// File: rtl/adc_result_regs_chk.sv
module adc_result_regs_chk
   import adc_regs_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 4,
   parameter int CH_W   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              conv_valid,
   input logic [CH_W-1:0]   conv_ch,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              burst_en,
   input logic [NUM_CH-1:0] ch_done,
   input logic [NUM_CH-1:0] ch_ovr,
   input logic [NUM_CH-1:0] int_en,
   input logic              irq
);
   // R3: a capture always leaves the channel flagged done
   a_r3_capture_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
      conv_valid |=> ch_done[$past(conv_ch)]);

   // R8: a status read leaves all flags untouched
   a_r8_status_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(A_STATUS) && !conv_valid)
      |=> ($stable(ch_done) && $stable(ch_ovr)));

   // R9: irq follows the enabled flags one cycle later
   a_r9_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == $past(|(ch_done & int_en))));

   for (genvar k = 0; k < NUM_CH; k++) begin : g_k
      // R4: a read with no capture into the same channel clears both flags
      a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && bus_addr == ADDR_W'(A_CHAN0 + k)
          && !(conv_valid && conv_ch == CH_W'(k)))
         |=> (!ch_done[k] && !ch_ovr[k]));
      // R5: a lost-result flag only rises from a burst-mode capture
      a_r5_ovr_needs_burst: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ch_ovr[k]) |-> $past(burst_en && conv_valid && conv_ch == CH_W'(k)));
   end
endmodule

bind adc_result_regs adc_result_regs_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_ch(conv_ch),
   .bus_addr(bus_addr), .bus_rd(bus_rd), .burst_en(burst_en),
   .ch_done(ch_done), .ch_ovr(ch_ovr), .int_en(int_en), .irq(irq));

// File: tb/adc_result_regs_test.sv
module adc_result_regs_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        conv_valid = 1'b0;
   logic [2:0]  conv_ch = '0;
   logic [9:0]  conv_data = '0;
   logic [3:0]  bus_addr = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   int          n_run = 0, n_fail = 0;
   logic [31:0] got;

   always #4 clk = ~clk;

   adc_result_regs uut (
      .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_ch(conv_ch),
      .conv_data(conv_data), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

   // {channel, value}
   localparam logic [12:0] VEC [0:7] = '{
      {3'd0, 10'h000}, {3'd7, 10'h3FF}, {3'd3, 10'h155}, {3'd1, 10'h2AA},
      {3'd6, 10'h001}, {3'd2, 10'h200}, {3'd5, 10'h0F0}, {3'd4, 10'h3FE}};

   function automatic logic [31:0] word(input logic d, input logic o,
                                        input logic [2:0] c, input logic [9:0] v);
      word = 32'h0;
      word[31] = d; word[30] = o; word[26:24] = c; word[15:6] = v;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic capture(input logic [2:0] c, input logic [9:0] v);
      @(negedge clk); conv_valid = 1'b1; conv_ch = c; conv_data = v;
      @(negedge clk); conv_valid = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk); bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk); bus_rd = 1'b0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      // R1 reset state
      do_reset();
      rd(4'd3, got); check("R1 status", got, 32'h0);
      rd(4'd1, got); check("R1 global", got, 32'h0);
      rd(4'd7, got); check("R1 chan3", got, 32'h0);
      rd(4'd2, got); check("R1 inten", got, 32'h0);
      rd(4'd0, got); check("R1 ctrl", got, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);

      // table walk: R2 R3 R4 R11
      for (int i = 0; i < 8; i++) begin
         capture(VEC[i][12:10], VEC[i][9:0]);
         rd(4'(4 + VEC[i][12:10]), got);
         check("R3 R2 R11 chan word", got, word(1'b1, 1'b0, VEC[i][12:10], VEC[i][9:0]));
         rd(4'(4 + VEC[i][12:10]), got);
         check("R4 chan cleared", got, word(1'b0, 1'b0, VEC[i][12:10], VEC[i][9:0]));
         rd(4'd1, got);
         check("R3 global word", got, word(1'b1, 1'b0, VEC[i][12:10], VEC[i][9:0]));
         rd(4'd3, got);
         check("R7 status empty", got, 32'h0);
      end

      // R5 burst overrun
      do_reset();
      wr(4'd0, 8'h01);
      rd(4'd0, got); check("R6 burst bit", got, 32'h1);
      capture(3'd2, 10'h111);
      capture(3'd2, 10'h222);
      rd(4'd3, got); check("R7 status flags", got, 32'h0000_0404);
      rd(4'd6, got); check("R5 chan overrun", got, word(1'b1, 1'b1, 3'd2, 10'h222));
      rd(4'd1, got); check("R5 global overrun", got, word(1'b1, 1'b1, 3'd2, 10'h222));
      rd(4'd6, got); check("R4 overrun cleared", got, word(1'b0, 1'b0, 3'd2, 10'h222));

      // R5 no overrun outside burst
      do_reset();
      capture(3'd5, 10'h010);
      capture(3'd5, 10'h020);
      rd(4'd9, got); check("R5 no burst no overrun", got, word(1'b1, 1'b0, 3'd5, 10'h020));

      // R6 control write clears global done only
      do_reset();
      capture(3'd1, 10'h3C0);
      wr(4'd0, 8'h00);
      rd(4'd1, got); check("R6 global cleared", got, word(1'b0, 1'b0, 3'd1, 10'h3C0));
      rd(4'd3, got); check("R6 chan flag kept", got, 32'h0000_0002);

      // R4 capture and read in the same cycle
      do_reset();
      wr(4'd0, 8'h01);
      capture(3'd4, 10'h0AA);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 4'd8;
      conv_valid = 1'b1; conv_ch = 3'd4; conv_data = 10'h155;
      #1 got = bus_rdata;
      @(negedge clk); bus_rd = 1'b0; conv_valid = 1'b0;
      check("R4 race old data read", got, word(1'b1, 1'b0, 3'd4, 10'h0AA));
      rd(4'd8, got); check("R4 race capture wins", got, word(1'b1, 1'b0, 3'd4, 10'h155));

      // R8 status read has no side effect
      do_reset();
      capture(3'd6, 10'h001);
      rd(4'd3, got); check("R8 status first", got, 32'h0000_0040);
      rd(4'd3, got); check("R8 status again", got, 32'h0000_0040);
      rd(4'd10, got); check("R8 chan still done", got, word(1'b1, 1'b0, 3'd6, 10'h001));

      // R9 R10 interrupt
      do_reset();
      capture(3'd3, 10'h2AA);
      wr(4'd2, 8'h08);
      check("R9 irq not yet", {31'b0, irq}, 32'h0);
      @(negedge clk);
      check("R9 irq raised", {31'b0, irq}, 32'h1);
      rd(4'd2, got); check("R10 inten readback", got, 32'h08);
      rd(4'd3, got); check("R7 status int bit", got, 32'h0001_0008);
      rd(4'd7, got);
      check("R9 irq held one cycle", {31'b0, irq}, 32'h1);
      @(negedge clk);
      check("R9 irq dropped", {31'b0, irq}, 32'h0);
      capture(3'd7, 10'h3FF);
      @(negedge clk);
      check("R9 disabled chan no irq", {31'b0, irq}, 32'h0);
      rd(4'd3, got); check("R9 status masked", got, 32'h0000_0080);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule